// File: doc/BRIEF.md
# Video DMA Descriptor List Walker

The walker runs through a list of DMA descriptors held in a local word-addressed memory. Software, or a sequencer, gives it a base address, a list length in 32-bit words and an interrupt-enable bit, then pulses `start`. The walker reads descriptors one word per two cycles. It always fetches four words first. It then looks at the packet type in the fourth word to learn whether the descriptor has four more words. Each complete descriptor goes out on a shared 256-bit word bus, together with one of three strobes: data transfer, configuration or control.

One control operation runs inside the block: "wait for channel". When this descriptor comes up, the walk halts until a completion pulse arrives for the channel that the descriptor names. A completion pulse that arrives early is held in a per-channel pending bit, so the wait cannot deadlock. When the consumed word count reaches the list length, the walker raises a one-cycle list-complete pulse, gated by the enable bit latched at start. A descriptor whose packet type is not recognised stops the walk and sets a sticky error flag.

Top module: `vdesc_walker`

## Requirements
- R1: After reset `busy`, `syncWait`, `listComplete`, `typeError` and all three descriptor strobes are 0.
- R2: A descriptor whose fourth word has bits [31:27] = 0x0B is emitted on `cfgValid` for one cycle. Its four words sit in `descWords` (word i at bits [32*i+31:32*i]), and words 4..7 read as zero.
- R3: Packet type 0x0A in bits [31:27] of the fourth word marks an eight-word descriptor. All eight words are emitted on `xferValid`.
- R4: Packet type 0x0C is emitted on `ctlValid`. If its control code (bits [3:0] of the fourth word) is anything other than 4, the walk continues with the next descriptor without waiting.
- R5: A control descriptor with code 4 stalls the walk with `syncWait` high. Only a completion pulse for the channel in bits [23:16] of its fourth word releases it. Pulses for other channels leave it stalled.
- R6: A completion pulse that arrives before its wait descriptor is held per channel and releases that wait at once. Each held pulse is consumed by exactly one wait.
- R7: Descriptors are processed in address order, advancing 4 or 8 words. The walk ends after the descriptor that brings the consumed word count to at least `listLen`. A `listLen` of 0 ends at once with no descriptor emitted.
- R8: On the end of a walk, `listComplete` is high for exactly one cycle if `irqEnable` was 1 at start. It stays low if `irqEnable` was 0.
- R9: Any other packet type stops the walk without emitting that descriptor or any later one, and without `listComplete`. It also sets `typeError`, which stays set until the next `start`.
- R10: At most one of the three descriptor strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (accepted only when idle) |
| listBase | input | ADDR_W | Word address of the first descriptor |
| listLen | input | ADDR_W+1 | List length in words |
| irqEnable | input | 1 | Enable for the list-complete pulse, latched at start |
| memRdEn | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory read address |
| memRdData | input | 32 | Read data, valid one cycle after the request |
| chanDone | input | 1 | Channel completion pulse |
| chanDoneId | input | 8 | Channel number of the completion pulse |
| xferValid | output | 1 | Data-transfer descriptor on `descWords` |
| cfgValid | output | 1 | Configuration descriptor on `descWords` |
| ctlValid | output | 1 | Control descriptor on `descWords` |
| descWords | output | 256 | Descriptor words, word 0 in the low bits |
| busy | output | 1 | Walk in progress |
| syncWait | output | 1 | Stalled on a wait-for-channel descriptor |
| listComplete | output | 1 | One-cycle end-of-list interrupt |
| typeError | output | 1 | Sticky unknown-packet-type flag |

## Verification
The assertions assume three things about the inputs:
- `memRdData` is the registered content of `memAddr` one cycle after `memRdEn`.
- No completion pulse lands on a channel in the same cycle that a held pulse for that channel is consumed.
- `start` is raised only while `busy` is low.

The bench keeps to these rules. It models a one-cycle synchronous memory and issues every pulse and start from the falling edge. It fires completion pulses only before a list starts, or while `syncWait` is visibly high. It starts each list only after observing `busy` low.

// File: rtl/vdw_pkg.sv
package vdw_pkg;
  localparam int WORD_W = 32;
  localparam int SRC_W  = 8;
  localparam int MAX_WORDS = 8;
  localparam logic [4:0] PKT_XFER = 5'h0A;
  localparam logic [4:0] PKT_CFG  = 5'h0B;
  localparam logic [4:0] PKT_CTL  = 5'h0C;
  localparam logic [3:0] CTL_CHAN_WAIT = 4'd4;

  typedef enum logic [1:0] {K_NONE, K_XFER, K_CFG, K_CTL} descKind_t;
  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CAP, S_DISP, S_SYNC, S_DONE, S_ERR} walkState_t;

  typedef struct packed {
    logic loadList;
    logic capture;
    logic extend;
    logic advance;
    logic consume;
  } strobes_t;
endpackage

// File: rtl/vdw_datapath.sv
module vdw_datapath
  import vdw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobes_t                  strb,
  input  logic [ADDR_W-1:0]         listBase,
  input  logic [LEN_W-1:0]          listLen,
  input  logic [WORD_W-1:0]         memRdData,
  input  logic                      chanDone,
  input  logic [SRC_W-1:0]          chanDoneId,
  output logic [ADDR_W-1:0]         memAddr,
  output logic [4:0]                capType,
  output logic                      lastWord,
  output logic                      need8,
  output logic [3:0]                ctlType,
  output logic                      syncReady,
  output logic                      endAfterStep,
  output logic                      endNow,
  output logic [MAX_WORDS*WORD_W-1:0] descWords
);
  localparam int NUM_CHAN = 1 << SRC_W;
  localparam logic [LEN_W:0] OFF_STEP4 = 4;
  localparam logic [LEN_W:0] OFF_STEP8 = 8;
  localparam logic [ADDR_W-1:0] ADR_STEP4 = 4;
  localparam logic [ADDR_W-1:0] ADR_STEP8 = 8;

  logic [ADDR_W-1:0] curAddr;
  logic [LEN_W:0]    offset, lenQ, stepW;
  logic [2:0]        wIdx;
  logic [WORD_W-1:0] words [MAX_WORDS];
  logic [NUM_CHAN-1:0] pend, hit, take;
  logic [SRC_W-1:0]  srcChan;

  assign memAddr  = curAddr + {{(ADDR_W-3){1'b0}}, wIdx};
  assign capType  = memRdData[31:27];
  assign lastWord = (wIdx == (need8 ? 3'd7 : 3'd3));
  assign ctlType  = words[3][3:0];
  assign srcChan  = words[3][23:16];
  assign stepW    = need8 ? OFF_STEP8 : OFF_STEP4;
  assign endAfterStep = (offset + stepW) >= lenQ;
  assign endNow   = offset >= lenQ;

  always_comb begin
    hit = '0;
    if (chanDone) hit[chanDoneId] = 1'b1;
    take = '0;
    if (strb.consume) take[srcChan] = 1'b1;
  end
  assign syncReady = pend[srcChan] | hit[srcChan];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      offset  <= '0;
      lenQ    <= '0;
      wIdx    <= '0;
      need8   <= 1'b0;
      pend    <= '0;
      for (int i = 0; i < MAX_WORDS; i++) words[i] <= '0;
    end else begin
      pend <= (pend | hit) & ~take;
      if (strb.loadList) begin
        curAddr <= listBase;
        offset  <= '0;
        lenQ    <= {1'b0, listLen};
        wIdx    <= '0;
        need8   <= 1'b0;
      end
      if (strb.capture) begin
        words[wIdx] <= memRdData;
        if (strb.extend) begin
          wIdx  <= 3'd4;
          need8 <= 1'b1;
        end else if (!lastWord) begin
          wIdx <= wIdx + 3'd1;
        end
      end
      if (strb.advance) begin
        offset  <= offset + stepW;
        curAddr <= curAddr + (need8 ? ADR_STEP8 : ADR_STEP4);
        wIdx    <= '0;
        need8   <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < MAX_WORDS; g++) begin : gOut
    if (g < 4) begin : gLow
      assign descWords[g*WORD_W +: WORD_W] = words[g];
    end else begin : gHigh
      assign descWords[g*WORD_W +: WORD_W] = need8 ? words[g] : '0;
    end
  end

  // R6: a completion pulse not consumed in its cycle leaves its channel pending
  assert_pend_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    (chanDone && !strb.consume) |=> pend[$past(chanDoneId)]);
endmodule

// File: rtl/vdw_control.sv
module vdw_control
  import vdw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     listLenZero,
  input  logic     irqEnable,
  input  logic     lastWord,
  input  logic     need8,
  input  logic [4:0] capType,
  input  logic [3:0] ctlType,
  input  logic     syncReady,
  input  logic     endAfterStep,
  input  logic     endNow,
  output strobes_t strb,
  output logic     memRdEn,
  output logic     xferValid,
  output logic     cfgValid,
  output logic     ctlValid,
  output logic     busy,
  output logic     syncWait,
  output logic     listComplete,
  output logic     typeError
);
  walkState_t st, nxt;
  descKind_t  kind, kindNxt;
  logic       irqQ;

  always_comb begin
    nxt     = st;
    kindNxt = kind;
    strb    = '0;
    memRdEn = 1'b0;
    case (st)
      S_IDLE: if (start) begin
        strb.loadList = 1'b1;
        nxt = listLenZero ? S_DONE : S_REQ;
      end
      S_REQ: begin
        memRdEn = 1'b1;
        nxt = S_CAP;
      end
      S_CAP: begin
        strb.capture = 1'b1;
        if (!lastWord) nxt = S_REQ;
        else if (need8) begin
          kindNxt = K_XFER;
          nxt = S_DISP;
        end else begin
          case (capType)
            PKT_XFER: begin strb.extend = 1'b1; nxt = S_REQ; end
            PKT_CFG:  begin kindNxt = K_CFG; nxt = S_DISP; end
            PKT_CTL:  begin kindNxt = K_CTL; nxt = S_DISP; end
            default:  nxt = S_ERR;
          endcase
        end
      end
      S_DISP: begin
        strb.advance = 1'b1;
        if (kind == K_CTL && ctlType == CTL_CHAN_WAIT) nxt = S_SYNC;
        else nxt = endAfterStep ? S_DONE : S_REQ;
      end
      S_SYNC: if (syncReady) begin
        strb.consume = 1'b1;
        nxt = endNow ? S_DONE : S_REQ;
      end
      S_DONE:  nxt = S_IDLE;
      S_ERR:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= S_IDLE;
      kind      <= K_NONE;
      irqQ      <= 1'b0;
      typeError <= 1'b0;
    end else begin
      st   <= nxt;
      kind <= kindNxt;
      if (strb.loadList) begin
        irqQ      <= irqEnable;
        typeError <= 1'b0;
      end else if (st == S_ERR) begin
        typeError <= 1'b1;
      end
    end
  end

  assign xferValid    = (st == S_DISP) && (kind == K_XFER);
  assign cfgValid     = (st == S_DISP) && (kind == K_CFG);
  assign ctlValid     = (st == S_DISP) && (kind == K_CTL);
  assign busy         = (st != S_IDLE);
  assign syncWait     = (st == S_SYNC);
  assign listComplete = (st == S_DONE) && irqQ;

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({xferValid, cfgValid, ctlValid}));
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    listComplete |=> !listComplete);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (typeError && !start) |=> typeError);
  assert_sync_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (syncWait && !syncReady) |=> syncWait);
endmodule

// File: rtl/vdesc_walker.sv
module vdesc_walker
  import vdw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LEN_W  = ADDR_W + 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             listBase,
  input  logic [LEN_W-1:0]              listLen,
  input  logic                          irqEnable,
  output logic                          memRdEn,
  output logic [ADDR_W-1:0]             memAddr,
  input  logic [WORD_W-1:0]             memRdData,
  input  logic                          chanDone,
  input  logic [SRC_W-1:0]              chanDoneId,
  output logic                          xferValid,
  output logic                          cfgValid,
  output logic                          ctlValid,
  output logic [MAX_WORDS*WORD_W-1:0]   descWords,
  output logic                          busy,
  output logic                          syncWait,
  output logic                          listComplete,
  output logic                          typeError
);
  strobes_t   strb;
  logic [4:0] capType;
  logic [3:0] ctlType;
  logic       lastWord, need8, syncReady, endAfterStep, endNow;

  vdw_control u_ctrl (
    .clk, .rstN, .start,
    .listLenZero(listLen == '0),
    .irqEnable, .lastWord, .need8, .capType, .ctlType, .syncReady,
    .endAfterStep, .endNow, .strb, .memRdEn,
    .xferValid, .cfgValid, .ctlValid, .busy, .syncWait, .listComplete, .typeError
  );

  vdw_datapath #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dp (
    .clk, .rstN, .strb, .listBase, .listLen, .memRdData, .chanDone, .chanDoneId,
    .memAddr, .capType, .lastWord, .need8, .ctlType, .syncReady,
    .endAfterStep, .endNow, .descWords
  );
endmodule

// File: tb/vdesc_walker_tb.sv
module vdesc_walker_tb;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 9;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] listBase = '0;
  logic [LEN_W-1:0]  listLen = '0;
  logic irqEnable = 1'b0;
  logic memRdEn;
  logic [ADDR_W-1:0] memAddr;
  logic [31:0] memRdData = '0;
  logic chanDone = 1'b0;
  logic [7:0] chanDoneId = '0;
  logic xferValid, cfgValid, ctlValid, busy, syncWait, listComplete, typeError;
  logic [255:0] descWords;

  always #2.5 clk = ~clk;

  vdesc_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dut (
    .clk, .rstN, .start, .listBase, .listLen, .irqEnable, .memRdEn, .memAddr,
    .memRdData, .chanDone, .chanDoneId, .xferValid, .cfgValid, .ctlValid,
    .descWords, .busy, .syncWait, .listComplete, .typeError
  );

  logic [31:0] mem [256];
  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];

  int checks = 0, fails = 0;
  int recN = 0, doneN = 0, dblPulse = 0, expN = 0, cycles = 0;
  logic [1:0]   recKind [16];
  logic [255:0] recWords [16];
  logic [1:0]   expKind [16];
  logic [255:0] expWords [16];
  logic prevDone = 1'b0;

  always @(negedge clk) begin
    if (xferValid | cfgValid | ctlValid) begin
      if (recN < 16) begin
        recKind[recN]  <= xferValid ? 2'd1 : cfgValid ? 2'd2 : 2'd3;
        recWords[recN] <= descWords;
      end
      recN <= recN + 1;
    end
    if (listComplete) doneN <= doneN + 1;
    if (listComplete && prevDone) dblPulse <= dblPulse + 1;
    prevDone <= listComplete;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // store descriptor words and append the expected emission
  task automatic addExp(input int kind, input int addr, input int n);
    logic [255:0] w = '0;
    for (int i = 0; i < n; i++) w[i*32 +: 32] = mem[(addr + i) % 256];
    expKind[expN]  = 2'(kind);
    expWords[expN] = w;
    expN++;
  endtask

  task automatic putCfg(input int addr, input int dest);
    mem[addr]   = 32'h1000_0000 + addr;
    mem[addr+1] = 32'h0000_0010;
    mem[addr+2] = 32'hC0DE_0000 + addr;
    mem[addr+3] = {5'h0B, 3'b001, 8'(dest), 16'h0004};
    addExp(2, addr, 4);
  endtask

  task automatic putCtl(input int addr, input int src, input int code);
    mem[addr] = 0; mem[addr+1] = 0; mem[addr+2] = 32'h0000_0055;
    mem[addr+3] = {5'h0C, 3'b000, 8'(src), 12'h000, 4'(code)};
    addExp(3, addr, 4);
  endtask

  task automatic putXfer(input int addr);
    for (int i = 0; i < 8; i++) mem[addr+i] = 32'hA500_0000 + (addr << 8) + i;
    mem[addr+3] = {5'h0A, 3'b010, 8'd7, 16'h0200};
    addExp(1, addr, 8);
  endtask

  task automatic startList(input int base, input int len, input bit irq);
    @(negedge clk);
    recN = 0; doneN = 0; dblPulse = 0;
    listBase = 8'(base); listLen = 9'(len); irqEnable = irq; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulseChan(input int ch);
    @(negedge clk);
    chanDone = 1'b1; chanDoneId = 8'(ch);
    @(negedge clk);
    chanDone = 1'b0;
  endtask

  task automatic checkRecs(input string tag);
    check(recN == expN, {tag, " emission count"}, recN, expN);
    for (int i = 0; i < expN && i < recN; i++) begin
      check(recKind[i] == expKind[i], {tag, " kind"}, recKind[i], expKind[i]);
      check(recWords[i] == expWords[i], {tag, " words"}, recWords[i][127:96], expWords[i][127:96]);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !syncWait && !listComplete && !typeError, "R1 idle outputs", busy, 0);
    check(!(xferValid | cfgValid | ctlValid), "R1 strobes low", xferValid, 0);
    rstN = 1'b1;

    // R2 R3 R4 R7 R8: mixed list
    expN = 0;
    putCfg(8'h10, 4); putXfer(8'h14); putCtl(8'h1C, 33, 2);
    startList(8'h10, 16, 1'b1); waitIdle();
    checkRecs("R2/R3/R4/R7 mixed list");
    check(doneN == 1, "R8 one completion", doneN, 1);
    check(dblPulse == 0, "R8 single-cycle pulse", dblPulse, 0);
    check(!typeError, "R9 no error on valid list", typeError, 0);

    // R8: completion masked
    startList(8'h10, 16, 1'b0); waitIdle();
    check(recN == 3, "R8 masked list still walks", recN, 3);
    check(doneN == 0, "R8 masked completion", doneN, 0);

    // R7: length shorter than list
    expN = 0; addExp(2, 8'h10, 4);
    startList(8'h10, 4, 1'b1); waitIdle();
    checkRecs("R7 truncated list");
    check(doneN == 1, "R7 truncated completion", doneN, 1);

    // R7: zero length
    startList(8'h10, 0, 1'b1); waitIdle();
    check(recN == 0 && doneN == 1, "R7 zero length", recN, 0);

    // R4: every non-wait control code passes through
    for (int c = 0; c < 9; c++) begin
      if (c == 4) continue;
      expN = 0;
      putCtl(8'h40, c * 3, c); putCfg(8'h44, c);
      startList(8'h40, 8, 1'b1); waitIdle();
      checkRecs($sformatf("R4 code %0d", c));
      check(doneN == 1, "R4 no stall", doneN, 1);
    end

    // R5: wait for channel 5
    expN = 0;
    putCtl(8'h60, 5, 4); putCfg(8'h64, 1);
    startList(8'h60, 8, 1'b1);
    repeat (40) @(negedge clk);
    check(recN == 1 && busy && syncWait, "R5 stalled", recN, 1);
    pulseChan(3);
    repeat (20) @(negedge clk);
    check(recN == 1 && syncWait, "R5 other channel ignored", recN, 1);
    check(doneN == 0, "R5 no completion while stalled", doneN, 0);
    pulseChan(5); waitIdle();
    checkRecs("R5 released");
    check(doneN == 1, "R5 completion", doneN, 1);

    // R6: early pulses remembered, then consumed
    expN = 0;
    pulseChan(9); pulseChan(200);
    putCtl(8'h70, 9, 4); putCtl(8'h74, 200, 4);
    startList(8'h70, 8, 1'b1); waitIdle();
    checkRecs("R6 early pulses");
    check(doneN == 1, "R6 completion", doneN, 1);
    expN = 0; putCtl(8'h80, 9, 4);
    startList(8'h80, 4, 1'b1);
    repeat (30) @(negedge clk);
    check(syncWait == 1'b1, "R6 held pulse consumed once", syncWait, 1);
    pulseChan(9); waitIdle();
    check(doneN == 1, "R6 release after consumption", doneN, 1);

    // R9: error stops walk
    expN = 0;
    putCfg(8'hA0, 2);
    mem[8'hA4] = 0; mem[8'hA5] = 0; mem[8'hA6] = 0; mem[8'hA7] = {5'h1F, 27'h0};
    putCfg(8'hA8, 3); expN = 1;
    startList(8'hA0, 12, 1'b1); waitIdle();
    checkRecs("R9 stop at bad type");
    check(typeError, "R9 error set", typeError, 1);
    check(doneN == 0, "R9 no completion", doneN, 0);
    repeat (5) @(negedge clk);
    check(typeError, "R9 error sticky", typeError, 1);
    startList(8'h10, 4, 1'b1); waitIdle();
    check(!typeError, "R9 cleared by start", typeError, 0);

    // R2 R3 R4 R9: sweep of all packet type codes
    for (int p = 0; p < 32; p++) begin
      for (int i = 0; i < 8; i++) mem[8'hB0 + i] = 32'h0B00_0000 + p * 16 + i;
      mem[8'hB3] = {5'(p), 27'h000_0001};
      expN = 0;
      if (p == 10) addExp(1, 8'hB0, 8);
      else if (p == 11) addExp(2, 8'hB0, 4);
      else if (p == 12) addExp(3, 8'hB0, 4);
      startList(8'hB0, 4, 1'b1); waitIdle();
      checkRecs($sformatf("R2/R3/R4/R9 type %0d", p));
      check(typeError == (expN == 0), "R9 sweep error flag", typeError, expN == 0);
      check(doneN == expN, "R8 sweep completion", doneN, expN);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule